// File: doc/BRIEF.md
# ADC Result Scaling and Clipping Formatter

This block converts a sampled input level into the 10-bit code that an analog-to-digital converter reports. It accepts a signed level in millivolts and a reference voltage in millivolts. The level is either a single-ended reading or a positive-minus-negative difference. Four mode flags go with each request: differential, bipolar, polarity invert and left adjust. The block scales the level against the reference using a signed sequential divider. It then applies the clip limits and encoding of the active mode, masks the code to 10 bits, and can place the code at the top of a 16-bit word.

Requests enter through a valid/ready handshake. Each request is one transaction. The result is presented on a second valid/ready handshake, together with a flag that reports saturation. The block works on one request at a time.

The control state machine has three states:

| State | Role | Transition |
|-------|------|------------|
| `ST_IDLE` | `in_ready` is high. | ACCEPT: `in_valid` and `in_ready` are both high. This starts the divider and moves to `ST_DIVIDE`. |
| `ST_DIVIDE` | The divider produces one quotient bit per cycle. | FINISH: the divider signals done. The clipped code is registered and the machine moves to `ST_PRESENT`. |
| `ST_PRESENT` | `out_valid` is high and the result is held. | RELEASE: `out_ready` is high. The machine returns to `ST_IDLE`. |

Top module: `adc_code_formatter`

## Requirements
- R1: In single-ended mode (`diff_mode`=0), the code is level×1023/reference. If that quotient is below 0 or above 1023, the code becomes 1023 (0x3FF).
- R2: In unipolar differential mode (`diff_mode`=1, `bipolar_mode`=0), the code is difference×1023/reference. If that quotient is below 0 or above 1023, the code becomes 0x1FF.
- R3: In bipolar differential mode (`diff_mode`=1, `bipolar_mode`=1), the code is difference×511/reference. A quotient above 511 becomes 0x1FF and a quotient below −511 becomes 0x200. In-range negative codes appear as 10-bit two's complement, which is the value masked with 0x3FF.
- R4: When `invert_pol`=1 in differential mode, the difference is negated before scaling. In single-ended mode, `invert_pol` has no effect on the code.
- R5: With `left_adj`=1, the 10-bit code occupies `out_code[15:6]` and bits [5:0] are zero. With `left_adj`=0, the code occupies `out_code[9:0]` and bits [15:10] are zero.
- R6: The division truncates toward zero for both signs of the level.
- R7: A reference of 0 produces the full-scale clip value of the active mode, with `out_clip`=1. That value is 0x3FF for single-ended mode and 0x1FF for both differential modes.
- R8: `out_clip` is 1 exactly when a clip substitution of R1, R2, R3 or R7 was applied, and 0 otherwise.
- R9: `in_ready` is high only in `ST_IDLE`. `out_valid` rises exactly LVL_W+12 cycles after the accepting clock edge, which is 28 cycles with the defaults.
- R10: While `out_valid`=1 and `out_ready`=0, `out_code` and `out_clip` hold steady. One cycle after a release, `out_valid`=0 and `in_ready`=1.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| in_valid | input | 1 | Request present |
| in_ready | output | 1 | Block can accept a request |
| in_level | input | LVL_W | Signed input level or difference, in mV |
| in_vref | input | REF_W | Unsigned reference, in mV |
| diff_mode | input | 1 | 1 = differential input |
| bipolar_mode | input | 1 | 1 = signed bipolar encoding (differential mode only) |
| invert_pol | input | 1 | 1 = negate the difference (differential mode only) |
| left_adj | input | 1 | 1 = left-justify the code in 16 bits |
| out_valid | output | 1 | Result present |
| out_ready | input | 1 | Consumer takes the result |
| out_code | output | 16 | Formatted code |
| out_clip | output | 1 | Saturation was applied |

## Verification
The assertions assume that `rst_n` is held low for at least one clock edge. They also assume that request fields are only sampled at an accepting edge. After acceptance the block works only from its own registered copy of the mode flags, so later changes on the inputs cannot disturb a check. The stimulus keeps `in_valid` low except for one cycle per request and drives `out_ready` only on falling edges. Levels stay within ±32767 mV and references within 0 to 65535 mV, so every product fits the divider width.

// File: rtl/adc_fmt_pkg.sv
package adc_fmt_pkg;
    localparam int CODE_W   = 10;
    localparam int OUT_W    = 16;
    localparam int GAIN_UNI = 1023;
    localparam int GAIN_BIP = 511;

    typedef enum logic [1:0] {
        ST_IDLE    = 2'd0,
        ST_DIVIDE  = 2'd1,
        ST_PRESENT = 2'd2
    } fmt_state_t;
endpackage

// File: rtl/adc_fmt_divider.sv
module adc_fmt_divider #(
    parameter int DIV_W = 27,
    parameter int REF_W = 16
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             start,
    input  logic [DIV_W-1:0] dividend,
    input  logic [REF_W-1:0] divisor,
    output logic             done,
    output logic [DIV_W-1:0] quotient
);
    localparam int CNT_W = $clog2(DIV_W + 1);

    logic [REF_W-1:0] rem_q;
    logic [REF_W-1:0] dsr_q;
    logic [DIV_W-1:0] dq_q;
    logic [CNT_W-1:0] cnt_q;
    logic             busy_q;
    logic [REF_W:0]   shifted;
    logic [REF_W:0]   diff_w;
    logic             take;

    always_comb begin
        shifted = {rem_q, dq_q[DIV_W-1]};
        diff_w  = shifted - {1'b0, dsr_q};
        take    = (shifted >= {1'b0, dsr_q});
    end

    always_ff @(posedge clk) begin
        if (!rst_n) begin
            rem_q  <= '0;
            dsr_q  <= '0;
            dq_q   <= '0;
            cnt_q  <= '0;
            busy_q <= 1'b0;
            done   <= 1'b0;
        end else if (start) begin
            rem_q  <= '0;
            dsr_q  <= divisor;
            dq_q   <= dividend;
            cnt_q  <= '0;
            busy_q <= 1'b1;
            done   <= 1'b0;
        end else if (busy_q) begin
            rem_q <= take ? diff_w[REF_W-1:0] : shifted[REF_W-1:0];
            dq_q  <= {dq_q[DIV_W-2:0], take};
            cnt_q <= cnt_q + 1'b1;
            if (cnt_q == CNT_W'(DIV_W - 1)) begin
                busy_q <= 1'b0;
                done   <= 1'b1;
            end
        end else begin
            done <= 1'b0;
        end
    end

    assign quotient = dq_q;

    p_done_pulse_r9: assert property (@(posedge clk) disable iff (!rst_n)
        done |=> !done);
    p_no_restart_r9: assert property (@(posedge clk) disable iff (!rst_n)
        busy_q |-> !start);
endmodule

// File: rtl/adc_fmt_clip.sv
module adc_fmt_clip #(
    parameter int QW = 28
) (
    input  logic signed [QW-1:0] q,
    input  logic                 diff,
    input  logic                 bipolar,
    input  logic                 zero_ref,
    input  logic                 left,
    output logic [15:0]          code,
    output logic                 clip
);
    import adc_fmt_pkg::*;

    localparam logic signed [QW-1:0] UNI_MAX = QW'(GAIN_UNI);
    localparam logic signed [QW-1:0] BIP_MAX = QW'(GAIN_BIP);
    localparam logic signed [QW-1:0] BIP_MIN = -QW'(GAIN_BIP);
    localparam int PAD = OUT_W - CODE_W;

    logic [CODE_W-1:0] c10;

    always_comb begin
        clip = 1'b0;
        c10  = q[CODE_W-1:0];
        if (zero_ref) begin
            clip = 1'b1;
            c10  = diff ? 10'h1FF : 10'h3FF;
        end else if (!diff || !bipolar) begin
            if (q < 0 || q > UNI_MAX) begin
                clip = 1'b1;
                c10  = diff ? 10'h1FF : 10'h3FF;
            end
        end else begin
            if (q > BIP_MAX) begin
                clip = 1'b1;
                c10  = 10'h1FF;
            end else if (q < BIP_MIN) begin
                clip = 1'b1;
                c10  = 10'h200;
            end
        end
        code = left ? {c10, {PAD{1'b0}}} : {{PAD{1'b0}}, c10};
    end
endmodule

// File: rtl/adc_code_formatter.sv
module adc_code_formatter #(
    parameter int LVL_W = 16,
    parameter int REF_W = 16
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             in_valid,
    output logic             in_ready,
    input  logic [LVL_W-1:0] in_level,
    input  logic [REF_W-1:0] in_vref,
    input  logic             diff_mode,
    input  logic             bipolar_mode,
    input  logic             invert_pol,
    input  logic             left_adj,
    output logic             out_valid,
    input  logic             out_ready,
    output logic [15:0]      out_code,
    output logic             out_clip
);
    import adc_fmt_pkg::*;

    localparam int DIV_W = LVL_W + 11;
    localparam int QW    = DIV_W + 1;

    fmt_state_t state_q, state_d;

    logic                    accept;
    logic signed [DIV_W-1:0] lvl_w;
    logic signed [DIV_W-1:0] gain_w;
    logic signed [DIV_W-1:0] num;
    logic        [DIV_W-1:0] mag;
    logic                    div_done;
    logic        [DIV_W-1:0] quo;
    logic signed [QW-1:0]    q_signed;
    logic        [15:0]      fmt_code;
    logic                    fmt_clip;

    logic r_diff, r_bip, r_left, r_neg, r_zero;

    // operand preparation: sign-extend, optional negate, apply gain
    always_comb begin
        lvl_w  = DIV_W'($signed(in_level));
        if (diff_mode && invert_pol)
            lvl_w = -lvl_w;
        gain_w = (diff_mode && bipolar_mode) ? DIV_W'(GAIN_BIP) : DIV_W'(GAIN_UNI);
        num    = lvl_w * gain_w;
        mag    = num[DIV_W-1] ? DIV_W'(-num) : DIV_W'(num);
    end

    assign accept = in_valid && in_ready;

    adc_fmt_divider #(.DIV_W(DIV_W), .REF_W(REF_W)) u_div (
        .clk      (clk),
        .rst_n    (rst_n),
        .start    (accept),
        .dividend (mag),
        .divisor  (in_vref),
        .done     (div_done),
        .quotient (quo)
    );

    assign q_signed = r_neg ? -$signed({1'b0, quo}) : $signed({1'b0, quo});

    adc_fmt_clip #(.QW(QW)) u_clip (
        .q        (q_signed),
        .diff     (r_diff),
        .bipolar  (r_bip),
        .zero_ref (r_zero),
        .left     (r_left),
        .code     (fmt_code),
        .clip     (fmt_clip)
    );

    // state register
    always_ff @(posedge clk) begin
        if (!rst_n) state_q <= ST_IDLE;
        else        state_q <= state_d;
    end

    // next state and handshake outputs
    always_comb begin
        state_d   = state_q;
        in_ready  = 1'b0;
        out_valid = 1'b0;
        unique case (state_q)
            ST_IDLE: begin
                in_ready = 1'b1;
                if (in_valid) state_d = ST_DIVIDE;
            end
            ST_DIVIDE: begin
                if (div_done) state_d = ST_PRESENT;
            end
            ST_PRESENT: begin
                out_valid = 1'b1;
                if (out_ready) state_d = ST_IDLE;
            end
            default: state_d = ST_IDLE;
        endcase
    end

    // captured mode and result registers
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            r_diff   <= 1'b0;
            r_bip    <= 1'b0;
            r_left   <= 1'b0;
            r_neg    <= 1'b0;
            r_zero   <= 1'b0;
            out_code <= '0;
            out_clip <= 1'b0;
        end else begin
            if (accept) begin
                r_diff <= diff_mode;
                r_bip  <= diff_mode && bipolar_mode;
                r_left <= left_adj;
                r_neg  <= num[DIV_W-1];
                r_zero <= (in_vref == '0);
            end
            if (state_q == ST_DIVIDE && div_done) begin
                out_code <= fmt_code;
                out_clip <= fmt_clip;
            end
        end
    end

    p_hold_r10: assert property (@(posedge clk) disable iff (!rst_n)
        out_valid && !out_ready |=> out_valid && $stable(out_code) && $stable(out_clip));
    p_release_r10: assert property (@(posedge clk) disable iff (!rst_n)
        out_valid && out_ready |=> !out_valid && in_ready);
    p_busy_r9: assert property (@(posedge clk) disable iff (!rst_n)
        accept |=> !in_ready);
    p_se_clip_r1: assert property (@(posedge clk) disable iff (!rst_n)
        out_valid && out_clip && !r_diff && !r_left |-> out_code == 16'h03FF);
    p_bip_clip_r3: assert property (@(posedge clk) disable iff (!rst_n)
        out_valid && out_clip && r_bip && !r_left |-> (out_code == 16'h01FF || out_code == 16'h0200));
    p_left_r5: assert property (@(posedge clk) disable iff (!rst_n)
        out_valid && r_left |-> out_code[5:0] == 6'd0);
    p_right_r5: assert property (@(posedge clk) disable iff (!rst_n)
        out_valid && !r_left |-> out_code[15:10] == 6'd0);
endmodule

// File: tb/adc_code_formatter_tb.sv
module adc_code_formatter_tb_top;
    localparam int LVL_W = 16;
    localparam int REF_W = 16;
    localparam int LAT   = LVL_W + 12;

    logic clk = 1'b0;
    logic rst_n = 1'b0;
    logic in_valid = 1'b0, in_ready;
    logic [LVL_W-1:0] in_level = '0;
    logic [REF_W-1:0] in_vref = '0;
    logic diff_mode = 1'b0, bipolar_mode = 1'b0, invert_pol = 1'b0, left_adj = 1'b0;
    logic out_valid, out_ready = 1'b0;
    logic [15:0] out_code;
    logic out_clip;

    int n_checks = 0;
    int n_fail = 0;

    always #2 clk = ~clk;

    adc_code_formatter #(.LVL_W(LVL_W), .REF_W(REF_W)) dut_i (
        .clk(clk), .rst_n(rst_n), .in_valid(in_valid), .in_ready(in_ready),
        .in_level(in_level), .in_vref(in_vref), .diff_mode(diff_mode),
        .bipolar_mode(bipolar_mode), .invert_pol(invert_pol), .left_adj(left_adj),
        .out_valid(out_valid), .out_ready(out_ready), .out_code(out_code),
        .out_clip(out_clip)
    );

    task automatic check(input string req, input string what, input longint act, input longint exp);
        n_checks++;
        if (act != exp) begin
            n_fail++;
            $display("FAIL %s %s: actual %0d expected %0d", req, what, act, exp);
        end
    endtask

    function automatic void model(input int lvl, input int vref, input bit d, input bit b,
                                  input bit inv, input bit l, output int code, output bit clip);
        longint n, q;
        int c;
        n = (d && inv) ? -lvl : lvl;
        n = n * ((d && b) ? 511 : 1023);
        clip = 1'b0;
        if (vref == 0) begin
            clip = 1'b1;
            c = d ? 'h1FF : 'h3FF;
        end else begin
            q = n / vref;
            c = int'(q & 'h3FF);
            if (!d || !b) begin
                if (q < 0 || q > 1023) begin
                    clip = 1'b1;
                    c = d ? 'h1FF : 'h3FF;
                end
            end else if (q > 511) begin
                clip = 1'b1; c = 'h1FF;
            end else if (q < -511) begin
                clip = 1'b1; c = 'h200;
            end
        end
        code = l ? (c << 6) : c;
    endfunction

    task automatic run(input string req, input int lvl, input int vref, input bit d,
                       input bit b, input bit inv, input bit l);
        int exp_code, cnt;
        bit exp_clip;
        model(lvl, vref, d, b, inv, l, exp_code, exp_clip);
        @(negedge clk);
        check("R9", "ready idle", in_ready, 1);
        in_valid = 1'b1; in_level = LVL_W'(lvl); in_vref = REF_W'(vref);
        diff_mode = d; bipolar_mode = b; invert_pol = inv; left_adj = l;
        @(negedge clk);
        in_valid = 1'b0;
        in_level = '1; diff_mode = ~d; left_adj = ~l;
        check("R9", "ready busy", in_ready, 0);
        cnt = 0;
        while (!out_valid && cnt < 200) begin
            @(negedge clk);
            cnt++;
        end
        check("R9", "latency", cnt, LAT);
        check(req, "code", out_code, exp_code);
        check("R8", "clip", out_clip, exp_clip);
        @(negedge clk);
        check("R10", "hold code", out_code, exp_code);
        check("R10", "hold valid", out_valid, 1);
        out_ready = 1'b1;
        @(negedge clk);
        out_ready = 1'b0;
        check("R10", "released", out_valid, 0);
        check("R10", "ready again", in_ready, 1);
    endtask

    task automatic t_single();
        run("R1", 1283, 2560, 0, 0, 0, 0);
        run("R1", 1200, 1100, 0, 0, 0, 0);
        run("R1", -5, 1100, 0, 0, 0, 0);
        run("R1", 0, 1100, 0, 0, 0, 0);
    endtask

    task automatic t_unipolar();
        run("R2", 100, 2560, 1, 0, 0, 0);
        run("R2", -100, 2560, 1, 0, 0, 0);
        run("R2", 3000, 2560, 1, 0, 0, 0);
    endtask

    task automatic t_bipolar();
        run("R3", 100, 2560, 1, 1, 0, 0);
        run("R3", 3000, 2560, 1, 1, 0, 0);
        run("R3", -1200, 1100, 1, 1, 0, 0);
        run("R3", -1100, 1100, 1, 1, 0, 0);
    endtask

    task automatic t_invert();
        run("R4", -100, 2560, 1, 0, 1, 0);
        run("R4", 1200, 1100, 1, 1, 1, 0);
        run("R4", 990, 1100, 0, 0, 1, 0);
    endtask

    task automatic t_left();
        run("R5", 386, 1100, 0, 0, 0, 1);
        run("R5", -2000, 2560, 1, 1, 0, 1);
    endtask

    task automatic t_trunc();
        run("R6", -2000, 2560, 1, 1, 0, 0);
        run("R6", 2215, 2560, 1, 1, 0, 0);
        run("R6", 32767, 65535, 0, 0, 0, 0);
    endtask

    task automatic t_zero_ref();
        run("R7", 500, 0, 0, 0, 0, 0);
        run("R7", 500, 0, 1, 0, 0, 0);
        run("R7", -500, 0, 1, 1, 0, 1);
    endtask

    initial begin
        repeat (3) @(negedge clk);
        check("R9", "reset ready", in_ready, 1);
        check("R10", "reset valid", out_valid, 0);
        rst_n = 1'b1;
        t_single();
        t_unipolar();
        t_bipolar();
        t_invert();
        t_left();
        t_trunc();
        t_zero_ref();
        $display("  [TB] %0d tests run, %0d failed", n_checks, n_fail);
        $finish;
    end

    initial begin
        repeat (100000) @(posedge clk);
        n_checks++;
        n_fail++;
        $display("FAIL R9 watchdog: actual timeout expected completion");
        $display("  [TB] %0d tests run, %0d failed", n_checks, n_fail);
        $finish;
    end
endmodule